// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two W-bit buses, called A and B, and moves data between them in either direction or in both directions at once. Each bus appears at the block as three pins: the value on the bus wire as seen now, the value the block would drive, and an enable that is high only when the block drives that wire. A surrounding fabric or testbench resolves each wire from these pins. All data the block drives is the bitwise inverse of the selected source.

Two storage registers sit inside. One captures bus A and the other captures bus B. Each has its own capture strobe and loads on a rising edge of that strobe, whatever the drive and select controls are doing. For each direction, a select picks either the live data on the opposite bus or the contents of that bus's storage register. When both buses are driven and both directions use live data, the block enters a bus-keeper mode. Each bus is driven with the value it held at the previous system clock edge, so it stays put once outside drivers let go.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high `rst`, sampled on the rising edge of `clk`, clears both storage registers and both bus-keeper registers to zero. After reset, a stored-source output therefore reads 0xFF for W=8.
- R2: On the first `clk` rising edge at which `cap_a` is high after being low at the previous edge, the A register loads `a_in`. `cap_b` and `b_in` load the B register in the same way. While a strobe stays high or stays low, its register keeps its value.
- R3: A capture takes place in every combination of `oe_a_n`, `oe_b`, `sel_ab` and `sel_ba`. This covers an isolated bus, a bus acting as an input, a bus the block is driving, and the bus-keeper mode.
- R4: `a_oe` is high exactly when `oe_a_n` is low. `b_oe` is high exactly when `oe_b` is high. All four combinations are valid: neither bus driven, A only, B only, or both.
- R5: While A is driven and not in bus-keeper mode, `a_out` is `~b_in` when `sel_ba` is 0 and the inverse of the B register when `sel_ba` is 1.
- R6: While B is driven and not in bus-keeper mode, `b_out` is `~a_in` when `sel_ab` is 0 and the inverse of the A register when `sel_ab` is 1.
- R7: Bus-keeper mode applies when both buses are driven and `sel_ab` = `sel_ba` = 0. In this mode `a_out` equals `a_in` sampled at the previous `clk` edge, and `b_out` equals `b_in` sampled at that edge, so each undriven-from-outside bus keeps its last value.
- R8: A bus output whose enable is low reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled and keeper registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cap_a | input | 1 | Capture strobe for the A register (rising edge loads) |
| cap_b | input | 1 | Capture strobe for the B register (rising edge loads) |
| oe_a_n | input | 1 | Low enables driving bus A |
| oe_b | input | 1 | High enables driving bus B |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_in | input | W | Resolved value of bus A |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | High when the block drives bus A |
| b_in | input | W | Resolved value of bus B |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | High when the block drives bus B |

## Verification
The two functions that can coincide are a strobe capture and bus-keeper operation. A capture edge can arrive while the only source on a bus is the block's own keeper feedback. The bench first loads both buses from outside drivers and then hands them over to keeper mode. It pulses each capture strobe while the buses are held only by the block. It then switches that direction to its stored source and checks that the register holds the held bus value and that the held value has not moved. A second overlap captures from a bus that the block is driving from the opposite register, and checks that the register receives the inverted data.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

    typedef enum logic [1:0] {
        XMODE_ISOLATE = 2'd0,
        XMODE_A_ONLY  = 2'd1,
        XMODE_B_ONLY  = 2'd2,
        XMODE_BOTH    = 2'd3
    } xmode_e;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
        logic keep;
    } drive_plan_t;

    function automatic xmode_e decode_mode(input logic oe_a_n, input logic oe_b);
        xmode_e m;
        unique case ({!oe_a_n, oe_b})
            2'b00:   m = XMODE_ISOLATE;
            2'b10:   m = XMODE_A_ONLY;
            2'b01:   m = XMODE_B_ONLY;
            default: m = XMODE_BOTH;
        endcase
        return m;
    endfunction

    function automatic drive_plan_t plan_for(input xmode_e m, input logic sel_ab,
                                             input logic sel_ba);
        drive_plan_t p;
        p.drive_a = (m == XMODE_A_ONLY) || (m == XMODE_BOTH);
        p.drive_b = (m == XMODE_B_ONLY) || (m == XMODE_BOTH);
        p.keep    = (m == XMODE_BOTH) && !sel_ab && !sel_ba;
        return p;
    endfunction

endpackage

// File: rtl/bxr_capture_reg.sv
module bxr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic strobe_d;
    logic load;

    assign load = strobe && !strobe_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b0;
            q        <= '0;
        end else begin
            strobe_d <= strobe;
            if (load) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/bxr_keeper_reg.sv
module bxr_keeper_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus,
    output logic [W-1:0] last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            last <= '0;
        end else begin
            last <= bus;
        end
    end
endmodule

// File: rtl/bxr_drive_ctl.sv
module bxr_drive_ctl
    import bxr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         oe_a_n,
    input  logic         oe_b,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_live,
    input  logic [W-1:0] b_live,
    input  logic [W-1:0] a_stored,
    input  logic [W-1:0] b_stored,
    input  logic [W-1:0] a_kept,
    input  logic [W-1:0] b_kept,
    output logic [W-1:0] a_drv,
    output logic         a_en,
    output logic [W-1:0] b_drv,
    output logic         b_en
);
    xmode_e      mode;
    drive_plan_t plan;
    logic [W-1:0] src_to_a;
    logic [W-1:0] src_to_b;
    logic [W-1:0] val_a;
    logic [W-1:0] val_b;

    always_comb begin
        mode     = decode_mode(oe_a_n, oe_b);
        plan     = plan_for(mode, sel_ab, sel_ba);
        src_to_a = sel_ba ? b_stored : b_live;
        src_to_b = sel_ab ? a_stored : a_live;
        if (plan.keep) begin
            val_a = a_kept;
            val_b = b_kept;
        end else begin
            val_a = ~src_to_a;
            val_b = ~src_to_b;
        end
        a_en  = plan.drive_a;
        b_en  = plan.drive_b;
        a_drv = plan.drive_a ? val_a : '0;
        b_drv = plan.drive_b ? val_b : '0;
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic         oe_a_n,
    input  logic         oe_b,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    localparam int SIDES = 2;

    logic [SIDES-1:0]        strobe_vec;
    logic [SIDES-1:0][W-1:0] bus_vec;
    logic [SIDES-1:0][W-1:0] stored_q;
    logic [SIDES-1:0][W-1:0] kept_q;
    logic [W-1:0]            reg_a_q;
    logic [W-1:0]            reg_b_q;

    assign strobe_vec = {cap_b, cap_a};
    assign bus_vec    = {b_in, a_in};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        bxr_capture_reg #(.W(W)) u_cap (
            .clk    (clk),
            .rst    (rst),
            .strobe (strobe_vec[s]),
            .d      (bus_vec[s]),
            .q      (stored_q[s])
        );
        bxr_keeper_reg #(.W(W)) u_keep (
            .clk  (clk),
            .rst  (rst),
            .bus  (bus_vec[s]),
            .last (kept_q[s])
        );
    end

    assign reg_a_q = stored_q[0];
    assign reg_b_q = stored_q[1];

    bxr_drive_ctl #(.W(W)) u_ctl (
        .oe_a_n   (oe_a_n),
        .oe_b     (oe_b),
        .sel_ab   (sel_ab),
        .sel_ba   (sel_ba),
        .a_live   (a_in),
        .b_live   (b_in),
        .a_stored (reg_a_q),
        .b_stored (reg_b_q),
        .a_kept   (kept_q[0]),
        .b_kept   (kept_q[1]),
        .a_drv    (a_out),
        .a_en     (a_oe),
        .b_drv    (b_out),
        .b_en     (b_oe)
    );
endmodule

// File: rtl/bxr_checks.sv
module bxr_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cap_a,
    input logic         cap_b,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic         a_oe,
    input logic         b_oe,
    input logic [W-1:0] reg_a_q,
    input logic [W-1:0] reg_b_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (reg_a_q == '0) && (reg_b_q == '0));

    assert_capture_a_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_a) |=> (reg_a_q == $past(a_in)));

    assert_capture_b_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_b) |=> (reg_b_q == $past(b_in)));

    assert_idle_a_R2: assert property (@(posedge clk) disable iff (rst)
        !cap_a |=> $stable(reg_a_q));

    assert_idle_b_R2: assert property (@(posedge clk) disable iff (rst)
        !cap_b |=> $stable(reg_b_q));

    assert_stored_a_R5: assert property (@(posedge clk) disable iff (rst)
        (a_oe && sel_ba && !(b_oe && !sel_ab && !sel_ba)) |-> (a_out == ~reg_b_q));

    assert_stored_b_R6: assert property (@(posedge clk) disable iff (rst)
        (b_oe && sel_ab) |-> (b_out == ~reg_a_q));

    assert_keeper_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && a_oe && b_oe && !sel_ab && !sel_ba)
            |-> (a_out == $past(a_in)) && (b_out == $past(b_in)));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!a_oe |-> (a_out == '0)) and (!b_oe |-> (b_out == '0)));
endmodule

bind bus_xcvr_reg bxr_checks #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_out   (a_out),
    .b_out   (b_out),
    .a_oe    (a_oe),
    .b_oe    (b_oe),
    .reg_a_q (reg_a_q),
    .reg_b_q (reg_b_q)
);

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cap_a = 1'b0, cap_b = 1'b0;
    logic         oe_a_n = 1'b1, oe_b = 1'b0;
    logic         sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] ext_a = '0, ext_b = '0;
    logic         ext_a_en = 1'b0, ext_b_en = 1'b0;
    logic [W-1:0] a_bus, b_bus, a_out, b_out;
    logic         a_oe, b_oe;
    int           checks = 0;
    int           failures = 0;
    bit           finished = 1'b0;

    always #2 clk = ~clk;

    assign a_bus = (ext_a_en ? ext_a : '0) | (a_oe ? a_out : '0);
    assign b_bus = (ext_b_en ? ext_b : '0) | (b_oe ? b_out : '0);

    bus_xcvr_reg #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .cap_a(cap_a), .cap_b(cap_b),
        .oe_a_n(oe_a_n), .oe_b(oe_b), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_bus), .b_out(b_out), .b_oe(b_oe)
    );

    // Contention on a wire means the drive enables (R4) are wrong.
    always @(negedge clk) begin
        if (!rst && ((ext_a_en && a_oe) || (ext_b_en && b_oe))) begin
            failures++;
            $display("FAIL R4 contention a_oe=%0b b_oe=%0b expected no block drive", a_oe, b_oe);
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic an, input logic bo, input logic sab, input logic sba);
        oe_a_n = an; oe_b = bo; sel_ab = sab; sel_ba = sba;
    endtask

    task automatic pulse(input bit side_b);
        @(negedge clk);
        if (side_b) cap_b = 1'b1; else cap_a = 1'b1;
        @(negedge clk);
        cap_a = 1'b0; cap_b = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        #1;
        check("R1 stored A after reset", b_out, 8'hFF);
        check("R1 stored B after reset", a_out, 8'hFF);
    endtask

    task automatic t_decode;
        @(negedge clk);
        ext_a_en = 1'b0; ext_b_en = 1'b0;
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1); #1;
        check("R4 isolate enables", {6'd0, a_oe, b_oe}, 8'h00);
        check("R8 isolate a_out zero", a_out, 8'h00);
        check("R8 isolate b_out zero", b_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1); #1;
        check("R4 A-only enables", {6'd0, a_oe, b_oe}, 8'h02);
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1); #1;
        check("R4 B-only enables", {6'd0, a_oe, b_oe}, 8'h01);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1); #1;
        check("R4 both enables", {6'd0, a_oe, b_oe}, 8'h03);
    endtask

    task automatic t_live;
        @(negedge clk);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        ext_b_en = 1'b1; ext_b = 8'h3C; #1;
        check("R5 live B onto A", a_out, 8'hC3);
        ext_b = 8'hA5; #1;
        check("R5 live B onto A second", a_out, 8'h5A);
        @(negedge clk);
        ext_b_en = 1'b0;
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        ext_a_en = 1'b1; ext_a = 8'h0F; #1;
        check("R6 live A onto B", b_out, 8'hF0);
        ext_a = 8'h81; #1;
        check("R6 live A onto B second", b_out, 8'h7E);
    endtask

    task automatic t_capture;
        @(negedge clk);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ext_a_en = 1'b1; ext_a = 8'h5A;
        ext_b_en = 1'b1; ext_b = 8'h96;
        pulse(1'b0);
        pulse(1'b1);
        ext_a = 8'h11; ext_b = 8'h22;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        ext_a_en = 1'b0; ext_b_en = 1'b0; #1;
        check("R2 R3 A capture while isolated", b_out, 8'hA5);
        check("R2 R3 B capture while isolated", a_out, 8'h69);
        // strobe held high: no second load
        @(negedge clk);
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        ext_a_en = 1'b1; ext_a = 8'h44;
        cap_a = 1'b1;
        @(negedge clk);
        ext_a = 8'h77;
        repeat (3) @(negedge clk);
        ext_a_en = 1'b0;
        cap_a = 1'b0;
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1); #1;
        check("R2 held strobe loads once", b_out, 8'hBB);
    endtask

    task automatic t_capture_driving;
        @(negedge clk);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        ext_a_en = 1'b0; ext_b_en = 1'b1; ext_b = 8'h33;
        pulse(1'b1);
        #1;
        check("R3 R5 B capture while A driven", a_out, 8'hCC);
        pulse(1'b0);
        ext_b_en = 1'b0;
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1); #1;
        check("R3 A capture from block-driven bus", b_out, 8'h33);
    endtask

    task automatic t_mixed;
        @(negedge clk);
        ext_a_en = 1'b0; ext_b_en = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b1); #1;
        check("R5 both driven A from stored B", a_out, 8'hCC);
        check("R6 both driven B live from A", b_out, 8'h33);
    endtask

    task automatic t_keeper;
        @(negedge clk);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ext_a_en = 1'b1; ext_a = 8'h6E;
        ext_b_en = 1'b1; ext_b = 8'h42;
        @(negedge clk);
        ext_a_en = 1'b0; ext_b_en = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0); #1;
        check("R7 keeper A first cycle", a_out, 8'h6E);
        check("R7 keeper B first cycle", b_out, 8'h42);
        repeat (4) @(negedge clk);
        check("R7 keeper A held", a_bus, 8'h6E);
        check("R7 keeper B held", b_bus, 8'h42);
        pulse(1'b0);
        pulse(1'b1);
        #1;
        check("R7 keeper A after captures", a_out, 8'h6E);
        check("R7 keeper B after captures", b_out, 8'h42);
        sel_ab = 1'b1; #1;
        check("R3 A capture in keeper mode", b_out, 8'h91);
        check("R5 live B after leaving keeper", a_out, 8'h6E);
        @(negedge clk);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1); #1;
        check("R3 B capture in keeper mode", a_out, 8'hBD);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_decode();
        t_live();
        t_capture();
        t_capture_driving();
        t_mixed();
        t_keeper();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule